// File: doc/BRIEF.md
# Paged I2C Register Target

This block is the host control port of a mixed-signal audio device. It answers on a two-wire I2C bus at one fixed 7-bit address. It gives the host byte-wide access to a paged control register space. A write transaction first loads a register pointer and then stores any number of data bytes at consecutive addresses. A read transaction returns bytes from the current pointer onward, and the pointer advances after every byte. Register 0 of every page selects the page that all later accesses use.

A few bit fields have side effects. One bit causes a full software reset, equal in effect to the hardware reset. Four bits emit one-cycle reset pulses for the headphone and speaker power stages. All of these bits clear themselves. For a fixed number of clock cycles after any reset, the coefficient pages are locked: host writes to them are dropped and host reads of them return zero. Internal blocks read any register through a parallel port. SCL and SDA are sampled through two-stage synchronisers. SDA is driven only as a pull-low enable.

Top module: `i2c_page_regs`

## Requirements
- R1: Only a first byte whose bits 7:1 equal 0x18 is acknowledged (SDA pulled low in the ninth clock); bit 0 of that byte selects read (1) or write (0). Any other address gets no acknowledge, and the bytes after it change no register.
- R2: In a write transaction, the byte after the address loads the register pointer. Each later byte is stored at the pointer, which then advances by one. Every byte is acknowledged, and a stored value reads back unchanged.
- R3: A read transaction returns the register at the current pointer and advances the pointer after each byte. It keeps going while the host acknowledges and stops sending after a host no-acknowledge.
- R4: Register 0 on any page holds the page number (its low log2(PAGES) bits). It reads back, and all later accesses use the new page. After reset the page is 0.
- R5: After reset is released, `lockout_active` stays high for exactly LOCK_CYCLES clock cycles. During that window, host writes to registers 1 and above on pages at or above COEF_PAGE are dropped and host reads of them return 0x00. Other pages work normally.
- R6: Writing page 1 register 31 with bit 7 or bit 6 set gives a one-cycle pulse on `hp_l_stage_rst` or `hp_r_stage_rst`. Register 32 does the same for `sp_l_stage_rst` and `sp_r_stage_rst`. Those two bits read back 0, the other bits are stored, and no other register changes.
- R7: Writing page 0 register 1 with bit 0 set is acknowledged. One cycle later it clears every register, sets the page to 0 and restarts the lockout window. The bit itself reads back 0.
- R8: While `hw_rst_n` is low at a clock edge, all registers and the page are cleared, the lockout window restarts, and SDA is released.
- R9: `int_rdata` shows the stored contents of register `int_reg` on page `int_page` combinationally (register 0 gives the page). The lockout does not gate this port.
- R10: A pointer value at or above REGS addresses nothing: writes there are dropped and reads return 0x00.
- R11: A repeated START restarts the address phase, so a write of the pointer followed by a read returns data from that pointer. A STOP returns the target to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| hw_rst_n | input | 1 | Hardware reset, active low, sampled on clk |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| int_page | input | log2(PAGES) | Page for the internal read port |
| int_reg | input | log2(REGS) | Register for the internal read port |
| int_rdata | output | 8 | Internal read data |
| lockout_active | output | 1 | Coefficient lockout window running |
| hp_l_stage_rst | output | 1 | Left headphone stage reset pulse |
| hp_r_stage_rst | output | 1 | Right headphone stage reset pulse |
| sp_l_stage_rst | output | 1 | Left speaker stage reset pulse |
| sp_r_stage_rst | output | 1 | Right speaker stage reset pulse |

## Verification
The address decode is swept over all 128 write addresses. Each address is followed by a pointer byte and a data byte, so a false match would show up as a corrupted register. A sequential write across all 63 data registers of one page, read back both over the bus and through the internal port, separates a working pointer increment from a stuck or skipping one. A burst that runs past the last register probes the out-of-range pointer. The lockout is tried before and after it expires, on a locked page and an open one, and its release cycle is counted exactly. Writes of mixed bit patterns to the stage-reset and soft-reset registers separate self-clearing bits from the bits that are stored.

// File: rtl/i2c_pr_pkg.sv
package i2c_pr_pkg;

    localparam logic [6:0] TARGET_ADDR = 7'h18;

    localparam int SWRST_PAGE  = 0;
    localparam int SWRST_REG   = 1;
    localparam int STAGE_PAGE  = 1;
    localparam int HP_STAGE_RG = 31;
    localparam int SP_STAGE_RG = 32;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_SKIP
    } eng_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_ev_t;

    typedef struct packed {
        logic       en;
        logic [7:0] ptr;
        logic [7:0] data;
    } host_wr_t;

    function automatic logic addr_hit(input logic [7:0] first_byte);
        return first_byte[7:1] == TARGET_ADDR;
    endfunction

    // Bits that are stored; self-clearing bits are masked off.
    function automatic logic [7:0] keep_mask(input int pg, input int rg);
        if (pg == SWRST_PAGE && rg == SWRST_REG)
            return 8'hFE;
        if (pg == STAGE_PAGE && (rg == HP_STAGE_RG || rg == SP_STAGE_RG))
            return 8'h3F;
        return 8'hFF;
    endfunction

endpackage

// File: rtl/i2c_pr_sync.sv
module i2c_pr_sync
    import i2c_pr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic [1:0] scl_ff, sda_ff;
    logic       scl_p, sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= 2'b11;
            sda_ff <= 2'b11;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[0], scl_i};
            sda_ff <= {sda_ff[0], sda_i};
            scl_p  <= scl_ff[1];
            sda_p  <= sda_ff[1];
        end
    end

    always_comb begin
        ev.sda      = sda_ff[1];
        ev.scl_rise = scl_ff[1] & ~scl_p;
        ev.scl_fall = ~scl_ff[1] & scl_p;
        ev.start    = scl_ff[1] & scl_p & sda_p & ~sda_ff[1];
        ev.stop     = scl_ff[1] & scl_p & ~sda_p & sda_ff[1];
    end

endmodule

// File: rtl/i2c_pr_engine.sv
module i2c_pr_engine
    import i2c_pr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_ev_t    ev,
    input  logic [7:0] rd_data,
    output logic [7:0] rd_ptr,
    output host_wr_t   wr,
    output logic       sda_oe,
    output eng_state_e state
);

    logic [3:0] bit_cnt;
    logic [7:0] rx_sh;
    logic [7:0] tx_sh;
    logic [7:0] ptr_q;
    logic       rw_q;

    assign rd_ptr = ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            ptr_q   <= '0;
            rw_q    <= 1'b0;
            sda_oe  <= 1'b0;
            wr      <= '0;
        end else begin
            wr.en <= 1'b0;
            if (ev.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (ev.start) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (ev.scl_rise) begin
                unique case (state)
                    ST_ADDR, ST_PTR, ST_WDATA: begin
                        rx_sh   <= {rx_sh[6:0], ev.sda};
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                    ST_RDATA:     bit_cnt <= bit_cnt + 4'd1;
                    ST_RDATA_ACK: if (ev.sda) state <= ST_SKIP;
                    default: ;
                endcase
            end else if (ev.scl_fall) begin
                unique case (state)
                    ST_ADDR: if (bit_cnt == 4'd8) begin
                        if (addr_hit(rx_sh)) begin
                            sda_oe <= 1'b1;
                            rw_q   <= rx_sh[0];
                            state  <= ST_ADDR_ACK;
                        end else begin
                            state  <= ST_SKIP;
                        end
                    end
                    ST_ADDR_ACK: begin
                        bit_cnt <= '0;
                        if (rw_q) begin
                            tx_sh  <= rd_data;
                            sda_oe <= ~rd_data[7];
                            ptr_q  <= ptr_q + 8'd1;
                            state  <= ST_RDATA;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_PTR;
                        end
                    end
                    ST_PTR: if (bit_cnt == 4'd8) begin
                        sda_oe <= 1'b1;
                        ptr_q  <= rx_sh;
                        state  <= ST_PTR_ACK;
                    end
                    ST_WDATA: if (bit_cnt == 4'd8) begin
                        sda_oe  <= 1'b1;
                        wr.en   <= 1'b1;
                        wr.ptr  <= ptr_q;
                        wr.data <= rx_sh;
                        ptr_q   <= ptr_q + 8'd1;
                        state   <= ST_WDATA_ACK;
                    end
                    ST_PTR_ACK, ST_WDATA_ACK: begin
                        sda_oe  <= 1'b0;
                        bit_cnt <= '0;
                        state   <= ST_WDATA;
                    end
                    ST_RDATA: begin
                        if (bit_cnt == 4'd8) begin
                            sda_oe <= 1'b0;
                            state  <= ST_RDATA_ACK;
                        end else begin
                            tx_sh  <= {tx_sh[6:0], 1'b0};
                            sda_oe <= ~tx_sh[6];
                        end
                    end
                    ST_RDATA_ACK: begin
                        bit_cnt <= '0;
                        tx_sh   <= rd_data;
                        sda_oe  <= ~rd_data[7];
                        ptr_q   <= ptr_q + 8'd1;
                        state   <= ST_RDATA;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_pr_regfile.sv
module i2c_pr_regfile
    import i2c_pr_pkg::*;
#(
    parameter int PAGES       = 16,
    parameter int REGS        = 64,
    parameter int COEF_PAGE   = 8,
    parameter int LOCK_CYCLES = 12000
) (
    input  logic                     clk,
    input  logic                     rst,
    input  host_wr_t                 wr,
    input  logic [7:0]               host_ptr,
    output logic [7:0]               host_rdata,
    input  logic [$clog2(PAGES)-1:0] int_page,
    input  logic [$clog2(REGS)-1:0]  int_reg,
    output logic [7:0]               int_rdata,
    output logic                     locked,
    output logic [3:0]               stage_pulse,
    output logic                     sw_pulse,
    output logic [$clog2(PAGES)-1:0] page_sel
);

    localparam int PG_W = $clog2(PAGES);
    localparam int RG_W = $clog2(REGS);
    localparam int LC_W = $clog2(LOCK_CYCLES + 1);

    logic [7:0]      mem [PAGES][REGS];
    logic [LC_W-1:0] lock_cnt;
    logic            rst_all;
    logic            wr_in_rng, rd_in_rng, coef_pg;
    logic [RG_W-1:0] wr_reg, rd_reg;
    logic            hit_hp, hit_sp;

    assign rst_all   = rst | sw_pulse;
    assign locked    = lock_cnt != '0;
    assign wr_in_rng = {1'b0, wr.ptr} < 9'(REGS);
    assign rd_in_rng = {1'b0, host_ptr} < 9'(REGS);
    assign wr_reg    = wr.ptr[RG_W-1:0];
    assign rd_reg    = host_ptr[RG_W-1:0];
    assign coef_pg   = {1'b0, page_sel} >= (PG_W+1)'(COEF_PAGE);
    assign hit_hp    = wr.en && wr_in_rng && page_sel == PG_W'(STAGE_PAGE) && wr_reg == RG_W'(HP_STAGE_RG);
    assign hit_sp    = wr.en && wr_in_rng && page_sel == PG_W'(STAGE_PAGE) && wr_reg == RG_W'(SP_STAGE_RG);

    always_ff @(posedge clk) begin
        if (rst_all) begin
            for (int p = 0; p < PAGES; p++)
                for (int r = 0; r < REGS; r++)
                    mem[p][r] <= '0;
            page_sel    <= '0;
            lock_cnt    <= LC_W'(LOCK_CYCLES);
            sw_pulse    <= 1'b0;
            stage_pulse <= '0;
        end else begin
            if (locked)
                lock_cnt <= lock_cnt - 1'b1;
            sw_pulse <= wr.en && wr_in_rng && page_sel == PG_W'(SWRST_PAGE)
                        && wr_reg == RG_W'(SWRST_REG) && wr.data[0];
            stage_pulse <= {hit_hp & wr.data[7], hit_hp & wr.data[6],
                            hit_sp & wr.data[7], hit_sp & wr.data[6]};
            if (wr.en && wr_in_rng) begin
                if (wr_reg == '0)
                    page_sel <= wr.data[PG_W-1:0];
                else if (!(coef_pg && locked))
                    mem[page_sel][wr_reg] <= wr.data & keep_mask(int'(page_sel), int'(wr_reg));
            end
        end
    end

    always_comb begin
        if (!rd_in_rng)
            host_rdata = '0;
        else if (rd_reg == '0)
            host_rdata = 8'(page_sel);
        else if (coef_pg && locked)
            host_rdata = '0;
        else
            host_rdata = mem[page_sel][rd_reg];
    end

    assign int_rdata = (int_reg == '0) ? 8'(page_sel) : mem[int_page][int_reg];

endmodule

// File: rtl/i2c_page_regs.sv
module i2c_page_regs
    import i2c_pr_pkg::*;
#(
    parameter int PAGES       = 16,
    parameter int REGS        = 64,
    parameter int COEF_PAGE   = 8,
    parameter int LOCK_CYCLES = 12000
) (
    input  logic                     clk,
    input  logic                     hw_rst_n,
    input  logic                     scl_i,
    input  logic                     sda_i,
    output logic                     sda_oe,
    input  logic [$clog2(PAGES)-1:0] int_page,
    input  logic [$clog2(REGS)-1:0]  int_reg,
    output logic [7:0]               int_rdata,
    output logic                     lockout_active,
    output logic                     hp_l_stage_rst,
    output logic                     hp_r_stage_rst,
    output logic                     sp_l_stage_rst,
    output logic                     sp_r_stage_rst
);

    logic                     rst;
    bus_ev_t                  ev;
    host_wr_t                 wr;
    logic [7:0]               host_ptr, host_rdata;
    eng_state_e               eng_state;
    logic [3:0]               stage_pulse;
    logic                     sw_pulse;
    logic [$clog2(PAGES)-1:0] page_sel;

    assign rst = ~hw_rst_n;

    i2c_pr_sync u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_pr_engine u_eng (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .rd_data (host_rdata),
        .rd_ptr  (host_ptr),
        .wr      (wr),
        .sda_oe  (sda_oe),
        .state   (eng_state)
    );

    i2c_pr_regfile #(
        .PAGES       (PAGES),
        .REGS        (REGS),
        .COEF_PAGE   (COEF_PAGE),
        .LOCK_CYCLES (LOCK_CYCLES)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr          (wr),
        .host_ptr    (host_ptr),
        .host_rdata  (host_rdata),
        .int_page    (int_page),
        .int_reg     (int_reg),
        .int_rdata   (int_rdata),
        .locked      (lockout_active),
        .stage_pulse (stage_pulse),
        .sw_pulse    (sw_pulse),
        .page_sel    (page_sel)
    );

    assign hp_l_stage_rst = stage_pulse[3];
    assign hp_r_stage_rst = stage_pulse[2];
    assign sp_l_stage_rst = stage_pulse[1];
    assign sp_r_stage_rst = stage_pulse[0];

endmodule

// File: rtl/i2c_page_regs_chk.sv
module i2c_page_regs_chk
    import i2c_pr_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       sda_oe,
    input eng_state_e eng_state,
    input logic       lockout_active,
    input logic       sw_pulse,
    input logic       page_zero,
    input logic [3:0] stage_pulse
);

    // R1: the line is never pulled while idle or ignoring a transfer
    assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (rst)
        (eng_state == ST_IDLE || eng_state == ST_SKIP) |-> !sda_oe);

    // R6: stage reset outputs are single-cycle pulses
    assert_stage_pulse_width_R6: assert property (@(posedge clk) disable iff (rst)
        (|stage_pulse) |=> !(|stage_pulse));

    // R7: a software reset reopens the lockout and returns to page 0
    assert_swrst_effect_R7: assert property (@(posedge clk) disable iff (rst)
        sw_pulse |=> (lockout_active && page_zero));

    // R7: the software reset request clears itself
    assert_swrst_self_clear_R7: assert property (@(posedge clk) disable iff (rst)
        sw_pulse |=> !sw_pulse);

    // R5: once released, the lockout stays released unless a reset occurs
    assert_lock_stays_open_R5: assert property (@(posedge clk) disable iff (rst)
        (!lockout_active && !sw_pulse) |=> !lockout_active);

endmodule

bind i2c_page_regs i2c_page_regs_chk chk_i (
    .clk            (clk),
    .rst            (rst),
    .sda_oe         (sda_oe),
    .eng_state      (eng_state),
    .lockout_active (lockout_active),
    .sw_pulse       (sw_pulse),
    .page_zero      (page_sel == '0),
    .stage_pulse    (stage_pulse)
);

// File: tb/i2c_page_regs_tb_top.sv
module i2c_page_regs_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LOCK       = 12000;
    localparam int Q          = 6;
    localparam logic [7:0] AW = 8'h30;
    localparam logic [7:0] AR = 8'h31;

    logic       clk = 1'b0;
    logic       hw_rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic [3:0] int_page = '0;
    logic [5:0] int_reg = '0;
    logic [7:0] int_rdata;
    logic       lockout_active;
    logic       hp_l, hp_r, sp_l, sp_r;

    int n_chk = 0, n_fail = 0;
    int cyc = 0, rel = 0;
    int c_hpl = 0, c_hpr = 0, c_spl = 0, c_spr = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (hp_l) c_hpl <= c_hpl + 1;
        if (hp_r) c_hpr <= c_hpr + 1;
        if (sp_l) c_spl <= c_spl + 1;
        if (sp_r) c_spr <= c_spr + 1;
    end

    assign sda_line = m_sda & ~sda_oe;

    i2c_page_regs dut_i (
        .clk            (clk),
        .hw_rst_n       (hw_rst_n),
        .scl_i          (m_scl),
        .sda_i          (sda_line),
        .sda_oe         (sda_oe),
        .int_page       (int_page),
        .int_reg        (int_reg),
        .int_rdata      (int_rdata),
        .lockout_active (lockout_active),
        .hp_l_stage_rst (hp_l),
        .hp_r_stage_rst (hp_r),
        .sp_l_stage_rst (sp_l),
        .sp_r_stage_rst (sp_r)
    );

    function automatic logic [7:0] pat(input int k);
        return 8'((k * 37 + 5) & 255);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i_start();
        m_sda = 1'b1; m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(2);
    endtask

    task automatic i_rstart();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(2);
    endtask

    task automatic i_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic send(input logic [7:0] b, output logic nack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(Q);
            m_scl = 1'b1; tick(Q);
            m_scl = 1'b0; tick(2);
        end
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q/2);
        nack = sda_line; tick(Q/2);
        m_scl = 1'b0; tick(2);
    endtask

    task automatic recv(input logic give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            m_scl = 1'b1; tick(Q/2);
            b[i] = sda_line; tick(Q/2);
            m_scl = 1'b0; tick(2);
        end
        m_sda = ~give_ack; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_scl = 1'b0; tick(2);
        m_sda = 1'b1;
    endtask

    task automatic wr1(input logic [7:0] ptr, input logic [7:0] d);
        logic n;
        i_start();
        send(AW, n);  chk("R2 address ack", n, 0);
        send(ptr, n); chk("R2 pointer ack", n, 0);
        send(d, n);   chk("R2 data ack", n, 0);
        i_stop();
    endtask

    task automatic rd1(input logic [7:0] ptr, output logic [7:0] d);
        logic n;
        i_start();
        send(AW, n); send(ptr, n);
        i_rstart();
        send(AR, n); chk("R11 read address ack", n, 0);
        recv(1'b0, d);
        i_stop();
    endtask

    task automatic wr_burst(input logic [7:0] ptr, input int cnt, input logic [7:0] xv);
        logic n;
        i_start();
        send(AW, n); send(ptr, n);
        for (int k = 0; k < cnt; k++) begin
            send(pat(int'(ptr) + k) ^ xv, n);
            chk("R2 burst data ack", n, 0);
        end
        i_stop();
    endtask

    task automatic peek(input int pg, input int rg, output logic [7:0] d);
        int_page = 4'(pg); int_reg = 6'(rg);
        #1 d = int_rdata;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic       n;
        int         c0, c1, c2, c3;

        // R8: hardware reset state
        tick(5);
        hw_rst_n = 1'b1; rel = cyc;
        chk("R8 sda released", sda_oe, 0);
        chk("R8 lockout running", lockout_active, 1);
        for (int p = 0; p < 16; p++)
            for (int r = 0; r < 64; r++) begin
                peek(p, r, d);
                chk("R8 R9 reset value", d, 0);
            end

        // R5: coefficient page locked during start-up window
        wr1(8'h00, 8'h08);
        wr1(8'h04, 8'h55);
        peek(8, 4, d); chk("R5 locked write dropped", d, 8'h00);
        rd1(8'h04, d); chk("R5 locked read is zero", d, 8'h00);
        rd1(8'h00, d); chk("R4 page reads back", d, 8'h08);
        wr1(8'h00, 8'h02);
        wr1(8'h04, 8'h66);
        peek(2, 4, d); chk("R5 open page writable in window", d, 8'h66);
        while (lockout_active && (cyc - rel) < LOCK + 50) tick(1);
        chk("R5 lockout length", cyc - rel, LOCK);
        wr1(8'h00, 8'h08);
        wr1(8'h04, 8'h55);
        peek(8, 4, d); chk("R5 write after window", d, 8'h55);
        rd1(8'h04, d); chk("R5 read after window", d, 8'h55);

        // R1: full address sweep, write direction
        wr1(8'h00, 8'h02);
        wr1(8'h0A, 8'h5A);
        for (int a = 0; a < 128; a++) begin
            i_start();
            send({7'(a), 1'b0}, n);
            chk("R1 address decode", n, (a == 8'h18) ? 0 : 1);
            send(8'h0A, n);
            send((a == 8'h18) ? 8'h5A : 8'hFF, n);
            i_stop();
        end
        peek(2, 10, d); chk("R1 foreign address changed nothing", d, 8'h5A);

        // R2 / R9: sequential write of every data register on page 2
        wr_burst(8'h01, 63, 8'h00);
        for (int r = 1; r < 64; r++) begin
            peek(2, r, d); chk("R2 R9 burst stored", d, pat(r));
        end

        // R3: sequential read of the same range
        i_start();
        send(AW, n); send(8'h01, n);
        i_rstart();
        send(AR, n);
        for (int r = 1; r < 64; r++) begin
            recv(r != 63, d);
            chk("R3 burst read", d, pat(r));
        end
        i_stop();

        // R4: page isolation and page width
        wr1(8'h00, 8'h03);
        wr1(8'h05, 8'hA3);
        peek(3, 5, d); chk("R4 page 3 write", d, 8'hA3);
        peek(2, 5, d); chk("R4 page 2 untouched", d, pat(5));
        wr1(8'h00, 8'hF2);
        rd1(8'h00, d); chk("R4 page uses low bits", d, 8'h02);
        rd1(8'h05, d); chk("R4 later access uses new page", d, pat(5));

        // R10: burst crossing the end of the register space
        wr_burst(8'h3E, 4, 8'hFF);
        peek(2, 62, d); chk("R10 last regs written", d, pat(62) ^ 8'hFF);
        peek(2, 63, d); chk("R10 last regs written", d, pat(63) ^ 8'hFF);
        rd1(8'h40, d);  chk("R10 out of range reads zero", d, 0);
        rd1(8'h46, d);  chk("R10 out of range reads zero", d, 0);
        peek(2, 0, d);  chk("R10 page not disturbed", d, 2);

        // R11: STOP in mid-transfer then new transaction
        i_start(); send(AW, n); send(8'h07, n); i_stop();
        i_start(); send(AR, n); recv(1'b0, d); i_stop();
        chk("R11 read continues at pointer", d, pat(7));

        // R6: power stage reset pulses
        wr1(8'h00, 8'h01);
        wr1(8'h1E, 8'h11);
        c0 = c_hpl; c1 = c_hpr; c2 = c_spl; c3 = c_spr;
        wr1(8'h1F, 8'hC5);
        tick(4);
        chk("R6 hp left pulse", c_hpl - c0, 1);
        chk("R6 hp right pulse", c_hpr - c1, 1);
        chk("R6 no speaker pulse", c_spl - c2 + c_spr - c3, 0);
        peek(1, 31, d); chk("R6 stage bits self clear", d, 8'h05);
        wr1(8'h20, 8'h80);
        tick(4);
        chk("R6 sp left pulse", c_spl - c2, 1);
        chk("R6 sp right idle", c_spr - c3, 0);
        peek(1, 32, d); chk("R6 speaker bits self clear", d, 8'h00);
        peek(1, 30, d); chk("R6 neighbour unchanged", d, 8'h11);

        // R7: software reset
        wr1(8'h00, 8'h00);
        wr1(8'h01, 8'h06);
        peek(0, 1, d); chk("R7 other bits stored", d, 8'h06);
        chk("R7 no reset without bit", lockout_active, 0);
        wr1(8'h01, 8'h07);
        chk("R7 lockout restarted", lockout_active, 1);
        peek(0, 1, d); chk("R7 reset bit reads zero", d, 8'h00);
        peek(2, 5, d); chk("R7 registers cleared", d, 8'h00);
        peek(3, 5, d); chk("R7 registers cleared", d, 8'h00);
        peek(8, 4, d); chk("R7 registers cleared", d, 8'h00);
        peek(0, 0, d); chk("R7 page back to 0", d, 8'h00);

        done = 1;
        summary();
        $finish;
    end

endmodule